// File: doc/BRIEF.md
# Heartbeat Watchdog Monitor

This block watches a software heartbeat line and pulls an active-low alarm output down when the line has stopped changing for too long. Rising and falling heartbeat transitions both count as a sign of life. Each transition restarts an internal timer. If the timer reaches its limit, the alarm latches low. It then waits for the next restart.

The monitor has three more controls. A drive-enable input tells the block whether the heartbeat line is being driven at all. When it is not, the watchdog is switched off and the alarm stays high. A reset-active input clears the timer for as long as the system sits in reset. A low-supply flag forces the alarm low and clears the timer. When the flag drops, the alarm goes high at once and a full new timeout period begins. The alarm output does not reset the system by itself. The surrounding logic decides what to do with it.

Top module: `wdog_heartbeat_mon`

## Requirements
- R1: While `rst_n` is low (sampled on the clock), the timer and the synchronizer are cleared and `wdt_out_n` reads 1 when `supply_low` is 0.
- R2: With the heartbeat steady, `beat_en` high and no clear source active, `wdt_out_n` falls exactly `TIMEOUT_CYC` clock edges after the last clearing edge. With the heartbeat held from reset release, it is low after the `TIMEOUT_CYC`-th rising clock edge and still high after edge `TIMEOUT_CYC-1`.
- R3: A heartbeat change of either polarity clears the timer on the third rising clock edge after it is applied. This covers two synchronizer flops plus one compare stage. The edge that clears the timer is not counted toward the next period.
- R4: Once low because of a timeout, `wdt_out_n` stays low for any number of cycles until a clear source occurs.
- R5: While `sys_rst_act` is 1, the timer is held cleared and `wdt_out_n` is 1 from the next clock edge. A full `TIMEOUT_CYC` period restarts after it drops.
- R6: While `beat_en` is 0, `wdt_out_n` is 1 without waiting for a clock edge (unless `supply_low` is 1), and the timer is held at zero. After re-enable a full period is needed.
- R7: While `supply_low` is 1, `wdt_out_n` is 0 without waiting for a clock edge, and the timer is held cleared.
- R8: When `supply_low` returns to 0, `wdt_out_n` is 1 at once, and the next timeout needs a full `TIMEOUT_CYC` edges.
- R9: A heartbeat that toggles at intervals shorter than the timeout keeps `wdt_out_n` high indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| beat_in | input | 1 | Asynchronous heartbeat line |
| beat_en | input | 1 | 1 when the heartbeat line is actively driven; 0 disables the watchdog |
| sys_rst_act | input | 1 | 1 while the system reset is asserted; clears the timer |
| supply_low | input | 1 | 1 while the supply is below its threshold |
| wdt_out_n | output | 1 | Active-low watchdog alarm |

## Verification
The bench builds the monitor with `TIMEOUT_CYC` = 16 and the default two synchronizer stages. A 16-edge period lets the bench reach many timeout expiries, restarts and clear windows within a few hundred cycles. It can therefore pin down the exact falling edge, the three-edge transition latency, and the full-period restart after each clear source. The bench also holds clear sources for several whole periods, which shows that the alarm cannot expire while they are active.

// File: rtl/wdog_pkg.sv
// Package: shared types and helpers for the heartbeat watchdog.
// Assumes: nothing beyond IEEE 1800-2017 elaboration-time functions.
package wdog_pkg;

    // Reasons that clear the watchdog timer on a clock edge.
    typedef struct packed {
        logic sys_rst;     // system reset asserted
        logic low_supply;  // supply below threshold
        logic idle;        // heartbeat line not driven
        logic beat_edge;   // synchronized heartbeat transition
    } clr_src_t;

    // Width needed to count 0 .. limit-1.
    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/wdog_beat_sync.sv
// Module: wdog_beat_sync
// Brings the asynchronous heartbeat into the clock domain through
// SYNC_STAGES flops. It adds one delayed copy and flags a transition
// whenever the last two stages differ.
// Assumes: SYNC_STAGES >= 2, and rst_n is synchronous to clk.
module wdog_beat_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beat_raw,
    output logic beat_edge
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    // Shift the heartbeat through the synchronizer and the delay stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[CHAIN_W-2:0], beat_raw};
        end
    end

    // A transition is present when the synchronized value differs from its delayed copy.
    assign beat_edge = chain[CHAIN_W-1] ^ chain[CHAIN_W-2];

endmodule

// File: rtl/wdog_counter.sv
// Module: wdog_counter
// Counts clock edges since the last clear. It sets a sticky expiry flag
// on the edge where the count would reach TIMEOUT_CYC. Any clear source
// zeroes both the count and the flag.
// Assumes: TIMEOUT_CYC >= 1, and rst_n is synchronous to clk.
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1000000
) (
    input  logic     clk,
    input  logic     rst_n,
    input  clr_src_t clr,
    output logic     expired
);
    localparam int            CW   = cnt_width(TIMEOUT_CYC);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt;
    logic          clear;

    // Any active clear source restarts the period.
    assign clear = |clr;

    // Advance the timer, latch expiry at the terminal count, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (!expired) begin
            if (cnt == LAST) begin
                expired <= 1'b1;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !expired && cnt != LAST) |=> (cnt == $past(cnt) + CW'(1)));

    // R2
    expire_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !expired && cnt == LAST) |=> expired);

    // R4
    expire_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clear) |=> (expired && $stable(cnt)));

    // R5
    clear_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0 && !expired));

endmodule

// File: rtl/wdog_outctl.sv
// Module: wdog_outctl
// Forms the active-low alarm. Low supply wins and pulls it low. A
// disabled watchdog keeps it high. Otherwise it follows the expiry flag.
// Assumes: all inputs are in the clk domain or are quasi-static levels.
module wdog_outctl (
    input  logic expired,
    input  logic beat_en,
    input  logic supply_low,
    output logic wdt_out_n
);
    // Combine the three conditions without any clock delay.
    always_comb begin
        if (supply_low) begin
            wdt_out_n = 1'b0;
        end else if (!beat_en) begin
            wdt_out_n = 1'b1;
        end else begin
            wdt_out_n = !expired;
        end
    end

endmodule

// File: rtl/wdog_heartbeat_mon.sv
// Module: wdog_heartbeat_mon (top)
// Heartbeat watchdog. It synchronizes the heartbeat and clears a timer
// on every transition or external clear condition. It raises an
// active-low alarm when TIMEOUT_CYC edges pass without a clear.
// Assumes: rst_n is synchronous, and sys_rst_act, supply_low and beat_en
// are clk-domain levels.
module wdog_heartbeat_mon
    import wdog_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1000000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beat_in,
    input  logic beat_en,
    input  logic sys_rst_act,
    input  logic supply_low,
    output logic wdt_out_n
);
    logic     beat_edge;
    logic     expired;
    clr_src_t clr;

    wdog_beat_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_raw  (beat_in),
        .beat_edge (beat_edge)
    );

    // Gather every condition that restarts the timing period.
    always_comb begin
        clr.sys_rst    = sys_rst_act;
        clr.low_supply = supply_low;
        clr.idle       = !beat_en;
        clr.beat_edge  = beat_edge;
    end

    wdog_counter #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .expired (expired)
    );

    wdog_outctl u_out (
        .expired    (expired),
        .beat_en    (beat_en),
        .supply_low (supply_low),
        .wdt_out_n  (wdt_out_n)
    );

    // R7
    supply_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |-> !wdt_out_n);

    // R6
    disable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_en && !supply_low) |-> wdt_out_n);

    // R3
    edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_edge |=> !expired);

    // R8
    supply_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(supply_low) && beat_en) |-> wdt_out_n);

endmodule

// File: tb/test_wdog_heartbeat_mon.sv
`timescale 1ns/100ps
module test_wdog_heartbeat_mon;
    localparam int TO = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic beat_in = 1'b0;
    logic beat_en = 1'b1;
    logic sys_rst_act = 1'b0;
    logic supply_low = 1'b0;
    logic wdt_out_n;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 0;

    wdog_heartbeat_mon #(.TIMEOUT_CYC(TO), .SYNC_STAGES(2)) i_wdog_heartbeat_mon (
        .clk         (clk),
        .rst_n       (rst_n),
        .beat_in     (beat_in),
        .beat_en     (beat_en),
        .sys_rst_act (sys_rst_act),
        .supply_low  (supply_low),
        .wdt_out_n   (wdt_out_n)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: wdt_out_n=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: sample history queue and an edge-run counter.
    bit hist[$] = '{0, 0, 0};
    int run_len = 0;
    bit m_exp = 0;

    always @(posedge clk) begin
        bit clr;
        logic want;
        clr = !rst_n || sys_rst_act || supply_low || !beat_en || (hist[1] != hist[2]);
        if (!rst_n) begin
            hist = '{0, 0, 0};
        end else begin
            hist.push_front(beat_in);
            void'(hist.pop_back());
        end
        if (clr) begin
            run_len = 0;
            m_exp = 0;
        end else if (!m_exp) begin
            run_len++;
            if (run_len >= TO) m_exp = 1;
        end
        #1;
        want = !supply_low && !(m_exp && beat_en);
        if (!finished) check("model R2 R3 R5", wdt_out_n, want);
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        step(4);
        check("R1 reset state", wdt_out_n, 1'b1);
        rst_n = 1'b1;
        step(TO - 1);
        check("R2 one edge before timeout", wdt_out_n, 1'b1);
        step(1);
        check("R2 timeout edge", wdt_out_n, 1'b0);
        step(20);
        check("R4 alarm stays latched", wdt_out_n, 1'b0);

        beat_in = 1'b1;
        step(2);
        check("R3 rise not yet through sync", wdt_out_n, 1'b0);
        step(1);
        check("R3 rise clears on third edge", wdt_out_n, 1'b1);
        step(TO - 1);
        check("R3 full period after rise", wdt_out_n, 1'b1);
        step(1);
        check("R3 expiry after rise", wdt_out_n, 1'b0);
        beat_in = 1'b0;
        step(3);
        check("R3 fall clears on third edge", wdt_out_n, 1'b1);

        for (int k = 0; k < 20; k++) begin
            beat_in = ~beat_in;
            step(5);
            check("R9 regular heartbeat keeps high", wdt_out_n, 1'b1);
        end

        step(TO + 5);
        check("R4 expiry before reset test", wdt_out_n, 1'b0);
        sys_rst_act = 1'b1;
        step(1);
        check("R5 reset clears alarm next edge", wdt_out_n, 1'b1);
        step(TO * 3);
        check("R5 no expiry during reset", wdt_out_n, 1'b1);
        sys_rst_act = 1'b0;
        step(TO - 1);
        check("R5 full period after reset", wdt_out_n, 1'b1);
        step(1);
        check("R5 expiry after reset", wdt_out_n, 1'b0);

        beat_en = 1'b0;
        #1;
        check("R6 disable raises at once", wdt_out_n, 1'b1);
        step(TO * 3);
        check("R6 disabled never expires", wdt_out_n, 1'b1);
        beat_en = 1'b1;
        step(TO - 1);
        check("R6 full period after enable", wdt_out_n, 1'b1);
        step(1);
        check("R6 expiry after enable", wdt_out_n, 1'b0);

        beat_in = ~beat_in;
        step(3);
        check("R3 recovery before supply test", wdt_out_n, 1'b1);
        supply_low = 1'b1;
        #1;
        check("R7 low supply forces low at once", wdt_out_n, 1'b0);
        step(TO * 2);
        check("R7 held low during low supply", wdt_out_n, 1'b0);
        supply_low = 1'b0;
        #1;
        check("R8 high at once on recovery", wdt_out_n, 1'b1);
        step(TO - 1);
        check("R8 full period after recovery", wdt_out_n, 1'b1);
        step(1);
        check("R8 expiry after recovery", wdt_out_n, 1'b0);

        step(5);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: run hung, done=%0b expected %0b", 1'b0, 1'b1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule